// File: doc/BRIEF.md
# Two-Way Write-Back Cache Controller

This block sits between a processor's word port and a main-memory port that moves one word per beat. Every processor address is split into three fields: a tag in the high bits, a set index in the middle bits, and a word offset in the low bits. Lookup uses only the set selected by the index. Each set holds `WAYS` lines. A line hits only when its stored tag equals the request tag and its valid flag is set.

A read that hits returns the addressed word. A write that hits changes only the cached copy and marks the line dirty. On a miss the controller picks a victim line in the set:

- If the victim is dirty, the controller first writes it back to memory.
- It then refills the line one word per memory-ready beat.
- It then replays the original request against the refilled line.

A write miss therefore allocates the line before the write is applied. Replacement tracks recency with a small age counter per line.

The processor holds its request, with fixed address and data, until it sees a one-cycle acknowledge. While the controller is moving data to or from memory, it raises a busy flag.

Top module: `wbc_cache`

## Requirements
- R1: After reset, `cpu_ack_o`, `cpu_busy_o` and `mem_req_o` are low and every line is invalid, so the first access to any address misses.
- R2: A hit completes without memory traffic. `cpu_ack_o` is high for exactly one cycle, and it rises in the cycle after the first rising edge that sees `cpu_req_i`. On a read, `cpu_rdata_o` holds the word while `cpu_ack_o` is high.
- R3: A hit requires both a tag match and a set valid flag. An access with a tag different from every valid line in the set misses, even when the set index and offset match a cached line.
- R4: A write hit updates only the cache and issues no memory beat. A later read of that address returns the written data.
- R5: A refill issues exactly 2^OFF_W read beats to addresses {request tag, set, k}, with k going 0, 1, … upward. One beat completes on each cycle where `mem_req_o` and `mem_ready_i` are both high. After the refill, a read returns the refilled word for its offset.
- R6: A write miss fetches the whole line first and then applies the write, so a later read returns the written word.
- R7: Evicting a dirty line writes back 2^OFF_W words to {victim tag, set, k} with k ascending, including every earlier write hit to that line. The write-back comes before the refill, and the refill's first beat follows the last write-back beat in the next cycle.
- R8: Evicting a clean line issues no write beat.
- R9: Each set holds distinct ages 0..WAYS-1, set at reset so that way w has age w. On every completed access:
  - the accessed line's age becomes 0;
  - lines younger than its old age age by one;
  - all other lines keep their age.
  
  When the set is full, the victim is the line with age WAYS-1.
- R10: If the set has an invalid way, the lowest-indexed invalid way is filled, and no valid line is evicted.
- R11: While `cpu_busy_o` is high, `mem_req_o` is high and `cpu_ack_o` stays low. Memory wait states lengthen the stall by the same number of cycles.
- R12: A memory beat that is not accepted keeps `mem_req_o`, `mem_we_o` and `mem_addr_o` unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor request, held until acknowledge |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address: {tag, set, offset} |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data, valid with acknowledge |
| cpu_ack_o | output | 1 | One-cycle completion pulse |
| cpu_busy_o | output | 1 | Write-back or refill in progress |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr_o | output | ADDR_W | Word address of the beat |
| mem_wdata_o | output | DATA_W | Write-back data |
| mem_rdata_i | input | DATA_W | Refill data |
| mem_ready_i | input | 1 | Beat accepted this cycle |

## Verification
Some internal faults are silent when they happen and only show up later at the ports:

- A stale or missing dirty flag appears only when that line is evicted: either the write-back beats are missing, or a later read returns old data after the refill.
- A corrupted age or a wrong victim choice appears as an extra refill on the next access to the line that should have stayed, which can be several accesses later.

Because of this delay, the bench runs a reference model of tags, valid and dirty flags, and ages. For every access it predicts the exact number of write-back and refill beats and their addresses. Random traffic is confined to a few sets and tags so that evictions and replays happen often.

// File: rtl/wbc_pkg.sv
`timescale 1ns/1ps
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FILL,
    ST_DONE
  } wbc_state_e;
endpackage

// File: rtl/wbc_store.sv
`timescale 1ns/1ps
module wbc_store #(
  parameter int SETS   = 16,
  parameter int WAYS   = 2,
  parameter int WPL    = 4,
  parameter int SET_W  = 4,
  parameter int OFF_W  = 2,
  parameter int WAY_W  = 1,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic [SET_W-1:0]                        set_i,
  input  logic                                    wr_en_i,
  input  logic                                    wr_dirty_i,
  input  logic [WAY_W-1:0]                        wr_way_i,
  input  logic [OFF_W-1:0]                        wr_off_i,
  input  logic [DATA_W-1:0]                       wr_data_i,
  input  logic                                    inst_en_i,
  input  logic [TAG_W-1:0]                        inst_tag_i,
  output logic [WAYS-1:0][TAG_W-1:0]              tag_o,
  output logic [WAYS-1:0]                         valid_o,
  output logic [WAYS-1:0]                         dirty_o,
  output logic [WAYS-1:0][WPL-1:0][DATA_W-1:0]    data_o
);
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [DATA_W-1:0] data_q  [SETS][WAYS][WPL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
      end
    end else begin
      if (inst_en_i) begin
        tag_q[set_i][wr_way_i]   <= inst_tag_i;
        valid_q[set_i][wr_way_i] <= 1'b1;
        dirty_q[set_i][wr_way_i] <= 1'b0;
      end else if (wr_en_i && wr_dirty_i) begin
        dirty_q[set_i][wr_way_i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[set_i][wr_way_i][wr_off_i] <= wr_data_i;
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      tag_o[w]   = tag_q[set_i][w];
      valid_o[w] = valid_q[set_i][w];
      dirty_o[w] = dirty_q[set_i][w];
      for (int o = 0; o < WPL; o++) data_o[w][o] = data_q[set_i][w][o];
    end
  end
endmodule

// File: rtl/wbc_lookup.sv
`timescale 1ns/1ps
module wbc_lookup #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1,
  parameter int TAG_W = 6
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           req_tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tag_i[w] == req_tag_i);
  end

  assign hit_o = |match;

  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wbc_lru.sv
`timescale 1ns/1ps
module wbc_lru #(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int SET_W = 4,
  parameter int WAY_W = 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [SET_W-1:0]                    set_i,
  input  logic                                touch_i,
  input  logic [WAY_W-1:0]                    touch_way_i,
  input  logic [WAYS-1:0]                     valid_i,
  output logic [WAY_W-1:0]                    victim_o,
  output logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] ages_o
);
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
  logic [WAY_W-1:0] old_age;
  logic             found_inv;

  assign old_age = age_q[set_i][touch_way_i];
  assign ages_o  = age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i) age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < old_age) age_q[set_i][w] <= age_q[set_i][w] + WAY_W'(1);
      end
    end
  end

  // invalid ways first (lowest index), else oldest
  always_comb begin
    victim_o  = '0;
    found_inv = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !found_inv) begin
        victim_o  = WAY_W'(w);
        found_inv = 1'b1;
      end
    end
    if (!found_inv) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[set_i][w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/wbc_cache.sv
`timescale 1ns/1ps
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SET_W  = 4,
  parameter int OFF_W  = 2,
  parameter int WAYS   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_ack_o,
  output logic              cpu_busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  localparam int SETS  = 1 << SET_W;
  localparam int WPL   = 1 << OFF_W;
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [TAG_W-1:0] req_tag;
  logic [SET_W-1:0] req_set;
  logic [OFF_W-1:0] req_off;

  assign req_tag = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign req_set = cpu_addr_i[OFF_W +: SET_W];
  assign req_off = cpu_addr_i[OFF_W-1:0];

  wbc_state_e        state_q;
  logic [OFF_W-1:0]  beat_q;
  logic [WAY_W-1:0]  vic_way_q;
  logic [TAG_W-1:0]  vic_tag_q;
  logic [DATA_W-1:0] rdata_q;

  logic [WAYS-1:0][TAG_W-1:0]           set_tag;
  logic [WAYS-1:0]                      set_valid;
  logic [WAYS-1:0]                      set_dirty;
  logic [WAYS-1:0][WPL-1:0][DATA_W-1:0] set_data;
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_all;

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim;
  logic             last_beat;
  logic             lookup;

  logic              wr_en, wr_dirty, inst_en, touch;
  logic [WAY_W-1:0]  wr_way;
  logic [OFF_W-1:0]  wr_off;
  logic [DATA_W-1:0] wr_data;

  assign lookup    = (state_q == ST_IDLE) && cpu_req_i;
  assign last_beat = (beat_q == OFF_W'(WPL - 1));

  wbc_store #(
    .SETS(SETS), .WAYS(WAYS), .WPL(WPL), .SET_W(SET_W), .OFF_W(OFF_W),
    .WAY_W(WAY_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(req_set),
    .wr_en_i(wr_en), .wr_dirty_i(wr_dirty), .wr_way_i(wr_way),
    .wr_off_i(wr_off), .wr_data_i(wr_data),
    .inst_en_i(inst_en), .inst_tag_i(req_tag),
    .tag_o(set_tag), .valid_o(set_valid), .dirty_o(set_dirty), .data_o(set_data)
  );

  wbc_lookup #(.WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_lookup (
    .tag_i(set_tag), .valid_i(set_valid), .req_tag_i(req_tag),
    .hit_o(hit), .hit_way_o(hit_way)
  );

  wbc_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_lru (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(req_set),
    .touch_i(touch), .touch_way_i(hit_way), .valid_i(set_valid),
    .victim_o(victim), .ages_o(age_all)
  );

  // datapath controls
  always_comb begin
    wr_en    = 1'b0;
    wr_dirty = 1'b0;
    wr_way   = hit_way;
    wr_off   = req_off;
    wr_data  = cpu_wdata_i;
    inst_en  = 1'b0;
    touch    = 1'b0;
    if (lookup && hit) begin
      touch    = 1'b1;
      wr_en    = cpu_we_i;
      wr_dirty = cpu_we_i;
    end else if (state_q == ST_FILL) begin
      wr_way  = vic_way_q;
      wr_off  = beat_q;
      wr_data = mem_rdata_i;
      wr_en   = mem_ready_i;
      inst_en = mem_ready_i && last_beat;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      beat_q    <= '0;
      vic_way_q <= '0;
      vic_tag_q <= '0;
      rdata_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cpu_req_i) begin
          if (hit) begin
            rdata_q <= cpu_we_i ? cpu_wdata_i : set_data[hit_way][req_off];
            state_q <= ST_DONE;
          end else begin
            vic_way_q <= victim;
            vic_tag_q <= set_tag[victim];
            beat_q    <= '0;
            state_q   <= (set_valid[victim] && set_dirty[victim]) ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: if (mem_ready_i) begin
          beat_q <= beat_q + OFF_W'(1);
          if (last_beat) state_q <= ST_FILL;
        end
        ST_FILL: if (mem_ready_i) begin
          beat_q <= beat_q + OFF_W'(1);
          if (last_beat) state_q <= ST_IDLE;  // replay request as a hit
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ack_o   = (state_q == ST_DONE);
  assign cpu_rdata_o = rdata_q;
  assign cpu_busy_o  = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_req_o   = cpu_busy_o;
  assign mem_we_o    = (state_q == ST_WBACK);
  assign mem_addr_o  = (state_q == ST_WBACK) ? {vic_tag_q, req_set, beat_q}
                                             : {req_tag, req_set, beat_q};
  assign mem_wdata_o = set_data[vic_way_q][beat_q];
endmodule

// File: rtl/wbc_cache_chk.sv
`timescale 1ns/1ps
module wbc_cache_chk #(
  parameter int ADDR_W = 12,
  parameter int SET_W  = 4,
  parameter int OFF_W  = 2,
  parameter int WAYS   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_ack_o,
  input logic              cpu_busy_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ready_i,
  input logic [(1<<SET_W)-1:0][WAYS-1:0][((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] ages_i
);
  localparam int SETS  = 1 << SET_W;
  localparam int WPL   = 1 << OFF_W;

  p_ack_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |=> !cpu_ack_o);

  p_busy_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_busy_o |-> (mem_req_o && !cpu_ack_o));

  p_beat_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_beat_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && (mem_addr_o[OFF_W-1:0] != OFF_W'(WPL - 1)))
    |=> (mem_req_o && (mem_we_o == $past(mem_we_o)) && (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))));

  p_wb_then_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && mem_we_o && (mem_addr_o[OFF_W-1:0] == OFF_W'(WPL - 1)))
    |=> (mem_req_o && !mem_we_o && (mem_addr_o[OFF_W-1:0] == '0)));

  for (genvar s = 0; s < SETS; s++) begin : g_age
    logic [WAYS-1:0] seen;
    always_comb begin
      seen = '0;
      for (int w = 0; w < WAYS; w++)
        if (int'(ages_i[s][w]) < WAYS) seen[ages_i[s][w]] = 1'b1;
    end
    p_age_perm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen == '1);
  end
endmodule

bind wbc_cache wbc_cache_chk #(
  .ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W), .WAYS(WAYS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_ack_o(cpu_ack_o), .cpu_busy_o(cpu_busy_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_ready_i(mem_ready_i), .ages_i(age_all)
);

// File: tb/wbc_cache_bench.sv
`timescale 1ns/1ps
module wbc_cache_bench;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int SET_W  = 4;
  localparam int OFF_W  = 2;
  localparam int WAYS   = 2;
  localparam int SETS   = 1 << SET_W;
  localparam int WPL    = 1 << OFF_W;
  localparam int SPACE  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic              cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic [DATA_W-1:0] cpu_rdata;
  logic              cpu_ack, cpu_busy;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic              mem_ready = 1'b0;

  always #2.5 clk = ~clk;

  wbc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W), .OFF_W(OFF_W), .WAYS(WAYS))
  u_wbc_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata), .cpu_ack_o(cpu_ack), .cpu_busy_o(cpu_busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
  );

  int n_cmp = 0, n_bad = 0;
  bit fin = 1'b0;
  logic [DATA_W-1:0] mem    [SPACE];
  logic [DATA_W-1:0] shadow [SPACE];

  int m_tag [SETS][WAYS];
  bit m_val [SETS][WAYS];
  bit m_dty [SETS][WAYS];
  int m_age [SETS][WAYS];

  int fill_cnt, wb_cnt, exp_wb_tag;
  logic [ADDR_W-1:0] cur_addr;

  function automatic logic [DATA_W-1:0] init_val(int a);
    return 32'hA500_0000 ^ DATA_W'(a * 65539);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory responder with random wait states; checks beat addresses (R5, R7)
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && ($urandom_range(0, 3) != 0)) begin
        mem_ready = 1'b1;
        if (mem_we) begin
          chk(mem_addr == ADDR_W'((exp_wb_tag << (SET_W + OFF_W)) |
                                  (int'(cur_addr[OFF_W +: SET_W]) << OFF_W) | (wb_cnt % WPL)),
              "R7 write-back beat address", mem_addr, 0);
          mem[mem_addr] = mem_wdata;
          wb_cnt++;
        end else begin
          chk(mem_addr == ((cur_addr & ~ADDR_W'(WPL - 1)) | ADDR_W'(fill_cnt % WPL)),
              "R5 refill beat address", mem_addr,
              (cur_addr & ~ADDR_W'(WPL - 1)) | ADDR_W'(fill_cnt % WPL));
          mem_rdata = mem[mem_addr];
          fill_cnt++;
        end
      end else begin
        mem_ready = 1'b0;
      end
    end
  end

  // reference model of lookup, victim choice and ages (R3, R8, R9, R10)
  task automatic model_access(input bit we, input logic [ADDR_W-1:0] a,
                              output bit hit, output int n_wb);
    int tag, set, way, old;
    tag = int'(a >> (SET_W + OFF_W));
    set = int'(a[OFF_W +: SET_W]);
    way = -1;
    n_wb = 0;
    for (int w = 0; w < WAYS; w++) if (m_val[set][w] && m_tag[set][w] == tag) way = w;
    hit = (way >= 0);
    if (!hit) begin
      for (int w = 0; w < WAYS; w++) if (!m_val[set][w] && way < 0) way = w;
      if (way < 0)
        for (int w = 0; w < WAYS; w++) if (m_age[set][w] == WAYS - 1) way = w;
      if (m_val[set][way] && m_dty[set][way]) begin
        n_wb = WPL;
        exp_wb_tag = m_tag[set][way];
      end
      m_tag[set][way] = tag;
      m_val[set][way] = 1'b1;
      m_dty[set][way] = 1'b0;
    end
    if (we) m_dty[set][way] = 1'b1;
    old = m_age[set][way];
    for (int w = 0; w < WAYS; w++) begin
      if (w == way) m_age[set][w] = 0;
      else if (m_age[set][w] < old) m_age[set][w]++;
    end
  endtask

  task automatic do_access(bit we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, string tags);
    bit hit;
    int n_wb, cyc;
    model_access(we, a, hit, n_wb);
    cur_addr = a;
    fill_cnt = 0;
    wb_cnt = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cpu_busy) chk(mem_req && !cpu_ack, {tags, " R11 stall"}, cpu_ack, 0);
    end while (!cpu_ack && cyc < 2000);
    chk(cpu_ack, {tags, " acknowledge"}, cpu_ack, 1);
    if (!we) chk(cpu_rdata == shadow[a], {tags, " R4 R5 R6 read data"}, cpu_rdata, shadow[a]);
    else shadow[a] = d;
    chk(wb_cnt == n_wb, {tags, " R7 R8 write-back beats"}, wb_cnt, n_wb);
    chk(fill_cnt == (hit ? 0 : WPL), {tags, " R3 R10 refill beats"}, fill_cnt, hit ? 0 : WPL);
    if (hit) chk(cyc == 1, {tags, " R2 hit latency"}, cyc, 1);
    cpu_req = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] mk(int tag, int set, int off);
    return ADDR_W'((tag << (SET_W + OFF_W)) | (set << OFF_W) | off);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < SPACE; a++) begin
      mem[a] = init_val(a);
      shadow[a] = init_val(a);
    end
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_val[s][w] = 1'b0; m_dty[s][w] = 1'b0; m_tag[s][w] = 0; m_age[s][w] = w;
      end
    repeat (3) @(negedge clk);
    chk(!cpu_ack && !cpu_busy && !mem_req, "R1 reset outputs",
        {cpu_ack, cpu_busy, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_ack && !mem_req, "R1 idle after reset", {cpu_ack, mem_req}, 0);

    do_access(1'b0, mk(1, 2, 1), '0, "R1 cold miss");
    do_access(1'b0, mk(1, 2, 1), '0, "R2 read hit");
    do_access(1'b0, mk(2, 2, 3), '0, "R3 R10 alias tag second way");
    do_access(1'b1, mk(1, 2, 2), 32'hDEAD_BEEF, "R4 write hit");
    do_access(1'b0, mk(3, 2, 0), '0, "R8 R9 clean victim");
    do_access(1'b0, mk(1, 2, 2), '0, "R9 recent line kept");
    do_access(1'b0, mk(4, 2, 0), '0, "R9 oldest replaced");
    do_access(1'b0, mk(5, 2, 0), '0, "R7 dirty eviction");
    do_access(1'b0, mk(1, 2, 2), '0, "R7 written data survives");
    do_access(1'b1, mk(6, 5, 3), 32'h1234_5678, "R6 write allocate");
    do_access(1'b0, mk(6, 5, 3), '0, "R6 read after allocate");

    for (int i = 0; i < 600; i++) begin
      bit we;
      we = ($urandom_range(0, 9) < 4);
      do_access(we, mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, WPL - 1)),
                $urandom(), "random R5 R7 R9");
    end
    // every line written back must read correctly from memory
    for (int i = 0; i < 40; i++)
      do_access(1'b0, mk($urandom_range(8, 11), $urandom_range(0, 3), $urandom_range(0, WPL - 1)),
                '0, "flush R7");
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < 4; s++)
        do_access(1'b0, mk(t, s, t % WPL), '0, "recheck R7");

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule